// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of signed three-axis acceleration samples and reports short spikes as taps. Each sample arrives with a one-cycle valid strobe. A separate one-cycle time-base tick gives the unit for the duration limit. An event starts on the first sample where any enabled axis has a magnitude above the threshold. It qualifies as a tap when a sample below the threshold arrives before the duration limit runs out. A qualified first tap raises a single-tap pulse at once.

After a single tap, the block waits through a dead time (the latency) and then opens a window. A second tap that starts inside that window and qualifies raises a double-tap pulse. The latency and the window are counted in gap units of `GAP_DIV` time-base ticks each. A suppress option cancels the pending double tap when the signal goes above the threshold during the dead time. Source flags report which axes took part in the tap that was last reported. The configuration inputs are threshold, duration, latency, window and an axis-control nibble. A zero in duration, latency or window turns off the function that depends on it.

Top module: `tap_detector`

## Requirements
- R1: An axis counts as above threshold on a valid sample when its enable bit is set and its absolute value, taken as an unsigned number, is strictly greater than `cfg_thresh`. In `cfg_axes`, bit 2 enables X, bit 1 enables Y and bit 0 enables Z. A disabled axis is never above threshold. The most negative sample value counts as the magnitude 2^(SW-1).
- R2: An event that starts with an above-threshold sample ends on the next valid sample that is not above threshold. If at most `cfg_dur` time-base ticks occurred during the event, `single_tap` is high for the clock cycle after that ending sample.
- R3: If a time-base tick arrives while an event is in progress and `cfg_dur` ticks have already passed, the event is discarded. No pulse is issued and the detector returns to idle.
- R4: While `cfg_dur` is 0, neither `single_tap` nor `double_tap` is ever asserted.
- R5: After a single tap, an above-threshold sample that arrives before `cfg_latent` gap units (each `GAP_DIV` time-base ticks) have elapsed does not start a second tap.
- R6: A second tap that begins after the latency has elapsed and before `cfg_window` further gap units have elapsed raises `double_tap` when it qualifies. `single_tap` is not raised for that tap. A sample that arrives after the window has closed starts a fresh first tap.
- R7: When `cfg_latent` or `cfg_window` is 0, no double tap is reported. Every qualified tap is reported as a single tap.
- R8: When `cfg_axes` bit 3 (suppress) is set, an above-threshold sample during the latency cancels the pending double tap. The detector returns to idle, and the next qualified tap is reported as a single tap. A double tap with no such sample is unaffected by suppress.
- R9: At each pulse, `tap_src` takes the OR of the axes that were above threshold during the reported tap: X in bit 2, Y in bit 1, Z in bit 0. It holds that value until the next pulse.
- R10: `single_tap` and `double_tap` are never high in the same cycle. Each pulse lasts exactly one cycle.
- R11: After synchronous reset, `single_tap`, `double_tap` and `tap_src` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_x | input | SW | Signed X-axis sample |
| smp_y | input | SW | Signed Y-axis sample |
| smp_z | input | SW | Signed Z-axis sample |
| tb_tick | input | 1 | Time-base tick, one-cycle pulse |
| cfg_thresh | input | TW | Unsigned magnitude threshold |
| cfg_dur | input | CW | Maximum event length in time-base ticks; 0 disables detection |
| cfg_latent | input | CW | Dead time after a first tap, in gap units |
| cfg_window | input | CW | Second-tap window after the dead time, in gap units |
| cfg_axes | input | 4 | Bit 3 suppress, bit 2 X enable, bit 1 Y enable, bit 0 Z enable |
| single_tap | output | 1 | One-cycle single-tap pulse |
| double_tap | output | 1 | One-cycle double-tap pulse |
| tap_src | output | 3 | Axes involved in the last reported tap |

## Verification
The hardest situation to reach is a second spike that lands exactly on the edge between the dead time and the window, or between the window and its expiry. Which pulse comes out depends on a count of time-base ticks taken after the single-tap pulse. The bench fixes each combination of latency and window values and issues a first tap. It then steps the start of the second spike one tick at a time, from immediately after the first tap to two ticks past the end of the window. For every offset it predicts from the tick arithmetic whether a double tap, a fresh single tap or nothing follows. The suppress case is reached in a similar way: a stray spike is placed inside the dead time, and a second tap is placed at the point where the window would be open.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int NAX = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAP1,
    ST_LAT,
    ST_WIN,
    ST_TAP2
  } tap_st_e;
endpackage

// File: rtl/tap_axis_cmp.sv
module tap_axis_cmp #(
  parameter int SW  = 16,
  parameter int TW  = 8,
  parameter int NAX = 3
) (
  input  logic                     smp_valid,
  input  logic [NAX-1:0][SW-1:0]   smp,
  input  logic [NAX-1:0]           en,
  input  logic [TW-1:0]            thr,
  output logic [NAX-1:0]           hit
);
  localparam int MW = SW + 1;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    logic [MW-1:0] mag;
    assign mag = smp[g][SW-1] ? ({1'b0, ~smp[g]} + MW'(1)) : {1'b0, smp[g]};
    assign hit[g] = smp_valid && en[g] && (mag > MW'(thr));
  end
endmodule

// File: rtl/tap_gap_div.sv
module tap_gap_div #(
  parameter int GAP_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tb_tick,
  output logic gap_tick
);
  localparam int DW = (GAP_DIV > 1) ? $clog2(GAP_DIV) : 1;

  logic [DW-1:0] div_q;

  assign gap_tick = tb_tick && (div_q == DW'(GAP_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      div_q <= '0;
    else if (tb_tick)
      div_q <= gap_tick ? '0 : div_q + DW'(1);
  end
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  input  logic           above,
  input  logic [NAX-1:0] hits,
  input  logic           tb_tick,
  input  logic           gap_tick,
  input  logic [CW-1:0]  cfg_dur,
  input  logic [CW-1:0]  cfg_latent,
  input  logic [CW-1:0]  cfg_window,
  input  logic           suppress,
  output logic           div_clr,
  output logic           single_tap,
  output logic           double_tap,
  output logic [NAX-1:0] tap_src
);
  tap_st_e        st_q, st_d;
  logic [CW-1:0]  dcnt_q, dcnt_d;
  logic [CW-1:0]  gcnt_q, gcnt_d;
  logic [NAX-1:0] acc_q, acc_d;
  logic [NAX-1:0] src_d;
  logic           sgl_d, dbl_d;

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    gcnt_d = gcnt_q;
    acc_d  = acc_q;
    src_d  = tap_src;
    sgl_d  = 1'b0;
    dbl_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cfg_dur != '0 && above) begin
          st_d   = ST_TAP1;
          dcnt_d = '0;
          acc_d  = hits;
        end
      end
      ST_TAP1, ST_TAP2: begin
        if (cfg_dur == '0) begin
          st_d = ST_IDLE;
        end else if (smp_valid && !above) begin
          src_d  = acc_q;
          gcnt_d = '0;
          if (st_q == ST_TAP1) begin
            sgl_d = 1'b1;
            st_d  = (cfg_latent == '0 || cfg_window == '0) ? ST_IDLE : ST_LAT;
          end else begin
            dbl_d = 1'b1;
            st_d  = ST_IDLE;
          end
        end else begin
          if (above)
            acc_d = acc_q | hits;
          if (tb_tick) begin
            if (dcnt_q == cfg_dur)
              st_d = ST_IDLE;
            else
              dcnt_d = dcnt_q + CW'(1);
          end
        end
      end
      ST_LAT: begin
        if (above && suppress) begin
          st_d = ST_IDLE;
        end else if (gap_tick) begin
          if (gcnt_q == cfg_latent - CW'(1)) begin
            st_d   = ST_WIN;
            gcnt_d = '0;
          end else begin
            gcnt_d = gcnt_q + CW'(1);
          end
        end
      end
      ST_WIN: begin
        if (above) begin
          st_d   = ST_TAP2;
          dcnt_d = '0;
          acc_d  = hits;
        end else if (gap_tick) begin
          if (gcnt_q == cfg_window - CW'(1))
            st_d = ST_IDLE;
          else
            gcnt_d = gcnt_q + CW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign div_clr = !(st_q == ST_LAT || st_q == ST_WIN) || (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      dcnt_q     <= '0;
      gcnt_q     <= '0;
      acc_q      <= '0;
      single_tap <= 1'b0;
      double_tap <= 1'b0;
      tap_src    <= '0;
    end else begin
      st_q       <= st_d;
      dcnt_q     <= dcnt_d;
      gcnt_q     <= gcnt_d;
      acc_q      <= acc_d;
      single_tap <= sgl_d;
      double_tap <= dbl_d;
      tap_src    <= src_d;
    end
  end
endmodule

// File: rtl/tap_detector.sv
module tap_detector
  import tap_pkg::*;
#(
  parameter int SW      = 16,
  parameter int TW      = 8,
  parameter int CW      = 8,
  parameter int GAP_DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_x,
  input  logic [SW-1:0] smp_y,
  input  logic [SW-1:0] smp_z,
  input  logic          tb_tick,
  input  logic [TW-1:0] cfg_thresh,
  input  logic [CW-1:0] cfg_dur,
  input  logic [CW-1:0] cfg_latent,
  input  logic [CW-1:0] cfg_window,
  input  logic [3:0]    cfg_axes,
  output logic          single_tap,
  output logic          double_tap,
  output logic [2:0]    tap_src
);
  logic [NAX-1:0][SW-1:0] smp_bus;
  logic [NAX-1:0]         hits;
  logic                   gap_tick;
  logic                   div_clr;

  assign smp_bus = {smp_x, smp_y, smp_z};

  tap_axis_cmp #(.SW(SW), .TW(TW), .NAX(NAX)) u_cmp (
    .smp_valid (smp_valid),
    .smp       (smp_bus),
    .en        (cfg_axes[NAX-1:0]),
    .thr       (cfg_thresh),
    .hit       (hits)
  );

  tap_gap_div #(.GAP_DIV(GAP_DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .clr      (div_clr),
    .tb_tick  (tb_tick),
    .gap_tick (gap_tick)
  );

  tap_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .above      (|hits),
    .hits       (hits),
    .tb_tick    (tb_tick),
    .gap_tick   (gap_tick),
    .cfg_dur    (cfg_dur),
    .cfg_latent (cfg_latent),
    .cfg_window (cfg_window),
    .suppress   (cfg_axes[3]),
    .div_clr    (div_clr),
    .single_tap (single_tap),
    .double_tap (double_tap),
    .tap_src    (tap_src)
  );
endmodule

// File: rtl/tap_detector_chk.sv
module tap_detector_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic [CW-1:0] cfg_dur,
  input logic          single_tap,
  input logic          double_tap,
  input logic [2:0]    tap_src
);
  // R10
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(single_tap && double_tap));

  // R10
  single_width_chk: assert property (@(posedge clk) disable iff (rst)
    single_tap |=> !single_tap);

  // R10
  double_width_chk: assert property (@(posedge clk) disable iff (rst)
    double_tap |=> !double_tap);

  // R2
  pulse_follows_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (single_tap || double_tap) |-> $past(smp_valid));

  // R9
  src_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (single_tap || double_tap) |-> (tap_src != 3'b000));

  // R4
  dur_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_dur) == '0) |-> (!single_tap && !double_tap));
endmodule

bind tap_detector tap_detector_chk u_chk (.*);

// File: tb/tb_tap_detector.sv
module tb_tap_detector;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic          tb_tick = 1'b0;
  logic [7:0]    cfg_thresh = 8'd20;
  logic [7:0]    cfg_dur = 8'd3;
  logic [7:0]    cfg_latent = 8'd1;
  logic [7:0]    cfg_window = 8'd1;
  logic [3:0]    cfg_axes = 4'b0111;
  logic          single_tap, double_tap;
  logic [2:0]    tap_src;

  int total = 0;
  int fails = 0;
  int n_sgl = 0;
  int n_dbl = 0;
  int viol = 0;
  logic prev_s = 1'b0, prev_d = 1'b0;

  always #4 clk = ~clk;

  tap_detector dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .tb_tick(tb_tick), .cfg_thresh(cfg_thresh), .cfg_dur(cfg_dur),
    .cfg_latent(cfg_latent), .cfg_window(cfg_window), .cfg_axes(cfg_axes),
    .single_tap(single_tap), .double_tap(double_tap), .tap_src(tap_src)
  );

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (single_tap) n_sgl++;
      if (double_tap) n_dbl++;
      if (single_tap && double_tap) viol++;
      if ((single_tap && prev_s) || (double_tap && prev_d)) viol++;
      prev_s = single_tap;
      prev_d = double_tap;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tb_tick = 1'b1;
    @(negedge clk) tb_tick = 1'b0;
  endtask

  task automatic smp(input logic [SW-1:0] x, input logic [SW-1:0] y, input logic [SW-1:0] z);
    @(negedge clk);
    smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
    @(negedge clk);
    smp_valid = 1'b0; smp_x = '0; smp_y = '0; smp_z = '0;
  endtask

  task automatic flush();
    smp('0, '0, '0);
    repeat (16) tick1();
  endtask

  task automatic tap(input logic [SW-1:0] x, input logic [SW-1:0] y, input logic [SW-1:0] z, input int len);
    smp(x, y, z);
    repeat (len) tick1();
    smp('0, '0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int s0, d0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 single", int'(single_tap), 0);
    chk("R11 double", int'(double_tap), 0);
    chk("R11 src", int'(tap_src), 0);

    // R1 / R9: threshold sweep on each axis and sign
    for (int ax = 0; ax < 3; ax++) begin
      for (int m = 19; m <= 21; m++) begin
        for (int sg = 0; sg < 2; sg++) begin
          logic [SW-1:0] v;
          v = sg ? SW'(-m) : SW'(m);
          s0 = n_sgl;
          tap(ax == 2 ? v : '0, ax == 1 ? v : '0, ax == 0 ? v : '0, 0);
          chk("R1 threshold single", n_sgl - s0, (m > 20) ? 1 : 0);
          if (m > 20) chk("R9 src axis", int'(tap_src), 1 << ax);
          flush();
        end
      end
    end

    // R1 disabled axis
    cfg_axes = 4'b0011;
    s0 = n_sgl;
    tap(SW'(100), '0, '0, 0);
    chk("R1 disabled X", n_sgl - s0, 0);
    flush();
    cfg_axes = 4'b0111;

    // R1 most negative value vs maximum threshold
    cfg_thresh = 8'd255;
    s0 = n_sgl;
    tap('0, '0, SW'(16'h8000), 0);
    chk("R1 most negative", n_sgl - s0, 1);
    chk("R9 src Z", int'(tap_src), 1);
    flush();
    cfg_thresh = 8'd20;

    // R9 accumulation of axes within one tap
    s0 = n_sgl;
    smp(SW'(50), '0, '0);
    smp('0, SW'(-50), '0);
    smp('0, '0, '0);
    chk("R9 accum single", n_sgl - s0, 1);
    chk("R9 accum src", int'(tap_src), 6);
    flush();

    // R2 / R3: duration sweep
    for (int d = 1; d <= 3; d++) begin
      cfg_dur = 8'(d);
      for (int len = 0; len <= d + 1; len++) begin
        s0 = n_sgl;
        tap(SW'(60), '0, '0, len);
        if (len <= d) chk("R2 duration qualifies", n_sgl - s0, 1);
        else          chk("R3 duration exceeded", n_sgl - s0, 0);
        flush();
      end
    end
    cfg_dur = 8'd3;

    // R4 duration zero
    cfg_dur = 8'd0;
    s0 = n_sgl; d0 = n_dbl;
    tap(SW'(60), '0, '0, 0);
    repeat (2) tick1();
    tap(SW'(60), '0, '0, 0);
    chk("R4 no single", n_sgl - s0, 0);
    chk("R4 no double", n_dbl - d0, 0);
    flush();
    cfg_dur = 8'd3;

    // R5 / R6: second-tap offset sweep (GAP_DIV = 2)
    for (int l = 1; l <= 2; l++) begin
      for (int w = 1; w <= 2; w++) begin
        cfg_latent = 8'(l); cfg_window = 8'(w);
        for (int k = 0; k <= 2 * (l + w) + 1; k++) begin
          bit in_win;
          in_win = (k >= 2 * l) && (k < 2 * (l + w));
          s0 = n_sgl; d0 = n_dbl;
          tap(SW'(70), '0, '0, 0);
          repeat (k) tick1();
          tap('0, SW'(70), '0, 0);
          if (k < 2 * l) begin
            chk("R5 latency singles", n_sgl - s0, 1);
            chk("R5 latency doubles", n_dbl - d0, 0);
          end else begin
            chk("R6 window singles", n_sgl - s0, in_win ? 1 : 2);
            chk("R6 window doubles", n_dbl - d0, in_win ? 1 : 0);
            if (in_win) chk("R9 double src Y", int'(tap_src), 2);
          end
          flush();
        end
      end
    end

    // R7 latency or window zero
    for (int c = 0; c < 2; c++) begin
      cfg_latent = c ? 8'd2 : 8'd0;
      cfg_window = c ? 8'd0 : 8'd2;
      s0 = n_sgl; d0 = n_dbl;
      tap(SW'(70), '0, '0, 0);
      repeat (c ? 4 : 0) tick1();
      tap(SW'(70), '0, '0, 0);
      chk("R7 singles", n_sgl - s0, 2);
      chk("R7 doubles", n_dbl - d0, 0);
      flush();
    end

    // R8 suppress vs no suppress with a stray spike in the latency
    cfg_latent = 8'd2; cfg_window = 8'd2;
    for (int sup = 0; sup < 2; sup++) begin
      cfg_axes = sup ? 4'b1111 : 4'b0111;
      s0 = n_sgl; d0 = n_dbl;
      tap(SW'(70), '0, '0, 0);
      tap(SW'(70), '0, '0, 0);
      repeat (4) tick1();
      tap(SW'(70), '0, '0, 0);
      chk("R8 singles", n_sgl - s0, sup ? 2 : 1);
      chk("R8 doubles", n_dbl - d0, sup ? 0 : 1);
      flush();
    end
    // R8 clean double with suppress set
    cfg_axes = 4'b1111;
    s0 = n_sgl; d0 = n_dbl;
    tap(SW'(70), '0, '0, 0);
    repeat (4) tick1();
    tap('0, '0, SW'(70), 0);
    chk("R8 clean double", n_dbl - d0, 1);
    chk("R8 clean single", n_sgl - s0, 1);
    chk("R9 src held", int'(tap_src), 1);
    flush();

    // R10 pulse shape across the whole run
    chk("R10 pulse violations", viol, 0);

    summary();
    $finish;
  end
endmodule